// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block is the timing master for a digital video encoder that drives interlaced 525-line or 625-line output. It counts samples of a 27 MHz clock to build lines and frames. From that count it produces an active-low horizontal sync, an active-low vertical sync, a flag naming the current field, a vertical-blanking flag and a gate that tells the caption inserter whether the current field may carry caption data.

Field identity is carried by the relation between the two sync edges. When both syncs fall together, an odd field starts. When vertical sync falls in mid-line while horizontal sync is high, an even field starts. A format input selects the line count, the line length and the vertical sync width. It is taken only at a frame boundary, so a frame is never cut short or stretched. Two further controls disable vertical-interval blanking and choose which fields carry captions.

Top module: `ivs_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counters go to line 1, sample 0, and the outputs go to `hsync_n`=1, `vsync_n`=1, `field_odd`=0, `vblank`=0, `cc_gate`=0. Every output is registered and shows the counter state of the previous clock. The first output after reset release is therefore line 1, sample 0: `hsync_n`=0, `vsync_n`=0, `field_odd`=1.
- R2: A line is `SPL_525` clocks long when `fmt_625`=0 and `SPL_625` clocks long when `fmt_625`=1 (defaults 1716 and 1728). Both values are multiples of 4. `hsync_n` is low for samples 0 to `HS_CLKS`-1 of every line, where the default of 128 is 64 pixels at two clocks per pixel. Sample 0 is a Cb slot, because samples repeat Cb, Y, Cr, Y from sample 0.
- R3: In 525-line mode, `vsync_n` is low for 3 lines in each field. It is low from line 1, sample 0, through the end of line 3. It is low again from line 263, sample `SPL_525`/2, through line 266, sample `SPL_525`/2-1.
- R4: In 625-line mode, `vsync_n` is low for 2.5 lines in each field. It is low from line 1, sample 0, through line 3, sample `SPL_625`/2-1. It is low again from line 313, sample `SPL_625`/2, through the end of line 315.
- R5: `field_odd` is 1 from line 1, sample 0, up to the mid-line point of line 263 (525-line mode) or line 313 (625-line mode), and 0 for the rest of the frame. It changes only in the cycle in which `vsync_n` falls. At an odd-field start both syncs fall in the same cycle. At an even-field start `vsync_n` falls while `hsync_n` is high.
- R6: `vblank` is 1 on whole lines 1-21, 262-284 and 525 in 525-line mode. It is 1 on lines 1-22, 311-335, 624 and 625 in 625-line mode. It is 0 on all other lines.
- R7: While `vbi_off`=1, `vblank` is 0 on every line, one clock after the control is sampled.
- R8: `cc_en[1]` enables caption data in odd fields and `cc_en[0]` enables it in even fields. With `cc_gate` = `field_odd ? cc_en[1] : cc_en[0]`, code 00 disables captions, 10 enables odd fields only, 01 enables even fields only, and 11 enables all fields. The output is registered one clock after `cc_en` is sampled.
- R9: A frame has 525 lines when the format is 0 and 625 lines when it is 1. `fmt_625` is sampled only at reset and at the last sample of a frame. A change in mid-frame leaves the line length, the sync timing and the blanking of the current frame untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| vbi_off | input | 1 | 1 suppresses vertical-interval blanking |
| cc_en | input | 2 | Caption field enables: bit 1 odd field, bit 0 even field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 during the odd field |
| vblank | output | 1 | Vertical blanking flag |
| cc_gate | output | 1 | Caption data permitted in the current field |

## Verification
The bench aims at the mid-line vertical sync edge of the even field. A generator that put this edge at a line start would show an even field with coincident sync edges, so the field identity would be lost. It checks the half-line vertical sync width in 625-line mode, where rounding to a whole line gives a pulse one half-line too long or too short. It checks the blanking limits at lines 21/22, 284/335 and 624-625, where an off-by-one range blanks a visible line or leaves a VBI line unblanked. It changes the format in mid-frame and expects the old line length to hold until the frame wraps. An unlatched format would leave a frame of neither length.

// File: rtl/ivs_pkg.sv
// Package: shared constants and types of the interlaced sync generator.
// Line counts, vertical sync widths in half-lines and blanking spans are
// fixed by the two line standards. Sample counts per line are parameters
// of the top module.
package ivs_pkg;

    localparam int LINES_525  = 525;
    localparam int LINES_625  = 625;
    localparam int LINE_W     = $clog2(LINES_625 + 1);
    localparam int HL_W       = LINE_W + 1;

    // vertical sync width counted in half-lines
    localparam int VS_HALVES_525 = 6;
    localparam int VS_HALVES_625 = 5;

    // number of blanked line spans per frame
    localparam int NSPAN = 3;

    typedef struct packed {
        logic [LINE_W-1:0] lo;
        logic [LINE_W-1:0] hi;
    } span_t;

    localparam span_t BLANK_525 [NSPAN] = '{
        '{LINE_W'(1),   LINE_W'(21)},
        '{LINE_W'(262), LINE_W'(284)},
        '{LINE_W'(525), LINE_W'(525)}
    };

    localparam span_t BLANK_625 [NSPAN] = '{
        '{LINE_W'(1),   LINE_W'(22)},
        '{LINE_W'(311), LINE_W'(335)},
        '{LINE_W'(624), LINE_W'(625)}
    };

endpackage

// File: rtl/ivs_hcount.sv
// Module: sample counter within a line.
// Counts from 0 to the line length minus one for the latched format and
// flags the last sample. Assumes fmt_q changes only at a frame boundary,
// which is also a line boundary.
module ivs_hcount #(
    parameter int SPL_525 = 1716,
    parameter int SPL_625 = 1728,
    localparam int H_W    = $clog2((SPL_625 > SPL_525 ? SPL_625 : SPL_525))
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fmt_q,
    output logic [H_W-1:0] h,
    output logic           eol
);

    localparam logic [H_W-1:0] LAST_525 = H_W'(SPL_525 - 1);
    localparam logic [H_W-1:0] LAST_625 = H_W'(SPL_625 - 1);

    // end of line: last sample for the current format
    always_comb begin
        eol = (h == (fmt_q ? LAST_625 : LAST_525));
    end

    // sample count: wraps at the end of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h <= '0;
        end else if (eol) begin
            h <= '0;
        end else begin
            h <= h + 1'b1;
        end
    end

endmodule

// File: rtl/ivs_vcount.sv
// Module: line counter and format latch.
// Counts lines from 1 to the frame length. The format input is captured
// at reset and at the last sample of each frame only, so a frame always
// completes in the format it started with.
module ivs_vcount
    import ivs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_625,
    input  logic              eol,
    output logic [LINE_W-1:0] line,
    output logic              fmt_q
);

    logic last_line;

    // last line of the frame for the latched format
    always_comb begin
        last_line = (line == (fmt_q ? LINE_W'(LINES_625) : LINE_W'(LINES_525)));
    end

    // line count and frame-boundary format capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line  <= LINE_W'(1);
            fmt_q <= fmt_625;
        end else if (eol) begin
            if (last_line) begin
                line  <= LINE_W'(1);
                fmt_q <= fmt_625;
            end else begin
                line <= line + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivs_decode.sv
// Module: sync, field, blanking and caption-gate decode with output registers.
// Position is mapped to a half-line index (2*(line-1) + second half). The
// even field starts at half-line index equal to the frame line count, and
// vertical sync spans a fixed number of half-lines from each field start.
// Outputs are registered, so they lag the counters by one clock.
module ivs_decode
    import ivs_pkg::*;
#(
    parameter int SPL_525 = 1716,
    parameter int SPL_625 = 1728,
    parameter int HS_CLKS = 128,
    localparam int H_W    = $clog2((SPL_625 > SPL_525 ? SPL_625 : SPL_525))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    h,
    input  logic [LINE_W-1:0] line,
    input  logic              fmt_q,
    input  logic              vbi_off,
    input  logic [1:0]        cc_en,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              field_odd,
    output logic              vblank,
    output logic              cc_gate
);

    localparam logic [H_W-1:0] HALF_525 = H_W'(SPL_525 / 2);
    localparam logic [H_W-1:0] HALF_625 = H_W'(SPL_625 / 2);
    localparam logic [H_W-1:0] HS_END   = H_W'(HS_CLKS);

    logic [HL_W-1:0] hl;
    logic [HL_W-1:0] frame_hl;
    logic [HL_W-1:0] vs_hl;
    logic            odd_now;
    logic            vs_now;
    logic [NSPAN-1:0] hit_525;
    logic [NSPAN-1:0] hit_625;
    logic            blank_now;

    // half-line position and format-dependent limits
    always_comb begin
        hl       = {line - LINE_W'(1), (h >= (fmt_q ? HALF_625 : HALF_525))};
        frame_hl = fmt_q ? HL_W'(LINES_625) : HL_W'(LINES_525);
        vs_hl    = fmt_q ? HL_W'(VS_HALVES_625) : HL_W'(VS_HALVES_525);
        odd_now  = (hl < frame_hl);
        vs_now   = (hl < vs_hl) || ((hl >= frame_hl) && (hl < frame_hl + vs_hl));
    end

    // one comparator pair per blanked span of each standard
    for (genvar i = 0; i < NSPAN; i++) begin : g_span
        assign hit_525[i] = (line >= BLANK_525[i].lo) && (line <= BLANK_525[i].hi);
        assign hit_625[i] = (line >= BLANK_625[i].lo) && (line <= BLANK_625[i].hi);
    end

    // blanking for the latched standard
    always_comb begin
        blank_now = fmt_q ? (|hit_625) : (|hit_525);
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n   <= 1'b1;
            vsync_n   <= 1'b1;
            field_odd <= 1'b0;
            vblank    <= 1'b0;
            cc_gate   <= 1'b0;
        end else begin
            hsync_n   <= !(h < HS_END);
            vsync_n   <= !vs_now;
            field_odd <= odd_now;
            vblank    <= blank_now && !vbi_off;
            cc_gate   <= odd_now ? cc_en[1] : cc_en[0];
        end
    end

endmodule

// File: rtl/ivs_sync_gen.sv
// Module: interlaced video sync generator, top level.
// Master-mode timing for 525/625-line interlaced video from a sample clock.
// Assumes SPL_525 and SPL_625 are multiples of 4 and HS_CLKS is below half
// a line. All outputs are registered.
module ivs_sync_gen
    import ivs_pkg::*;
#(
    parameter int SPL_525 = 1716,
    parameter int SPL_625 = 1728,
    parameter int HS_CLKS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_625,
    input  logic       vbi_off,
    input  logic [1:0] cc_en,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       field_odd,
    output logic       vblank,
    output logic       cc_gate
);

    localparam int H_W = $clog2((SPL_625 > SPL_525 ? SPL_625 : SPL_525));

    logic [H_W-1:0]    h;
    logic              eol;
    logic [LINE_W-1:0] line;
    logic              fmt_q;

    ivs_hcount #(
        .SPL_525 (SPL_525),
        .SPL_625 (SPL_625)
    ) hcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fmt_q (fmt_q),
        .h     (h),
        .eol   (eol)
    );

    ivs_vcount vcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_625 (fmt_625),
        .eol     (eol),
        .line    (line),
        .fmt_q   (fmt_q)
    );

    ivs_decode #(
        .SPL_525 (SPL_525),
        .SPL_625 (SPL_625),
        .HS_CLKS (HS_CLKS)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .h         (h),
        .line      (line),
        .fmt_q     (fmt_q),
        .vbi_off   (vbi_off),
        .cc_en     (cc_en),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .field_odd (field_odd),
        .vblank    (vblank),
        .cc_gate   (cc_gate)
    );

endmodule

// File: rtl/ivs_sync_gen_chk.sv
// Module: assertion checker for the sync generator, bound to the top.
// Watches only the top-level ports. The sync pulse width is checked with
// a local run-length counter, so the window does not depend on a large delay.
module ivs_sync_gen_chk #(
    parameter int HS_CLKS = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vbi_off,
    input logic [1:0] cc_en,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       field_odd,
    input logic       vblank,
    input logic       cc_gate
);

    logic [15:0] hs_run;

    // length of the current low run of hsync_n
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_run <= '0;
        end else if (!hsync_n) begin
            hs_run <= hs_run + 16'd1;
        end else begin
            hs_run <= '0;
        end
    end

    // R2: every horizontal sync pulse is exactly HS_CLKS clocks wide
    p_hs_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hs_run == 16'(HS_CLKS)));

    // R5: an odd-field start has both syncs falling together
    p_odd_coincide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) && field_odd) |-> $fell(hsync_n));

    // R5: an even-field start has vsync falling while hsync is high
    p_even_hs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) && !field_odd) |-> hsync_n);

    // R5: the field flag moves only with a vertical sync fall
    p_field_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $fell(vsync_n));

    // R7: blanking disabled means no blanking flag one clock later
    p_vbi_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vbi_off) |-> !vblank);

    // R8: caption code 00 keeps the gate closed
    p_cc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cc_en) == 2'b00) |-> !cc_gate);

endmodule

bind ivs_sync_gen ivs_sync_gen_chk #(.HS_CLKS(HS_CLKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vbi_off   (vbi_off),
    .cc_en     (cc_en),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .field_odd (field_odd),
    .vblank    (vblank),
    .cc_gate   (cc_gate)
);

// File: tb/ivs_sync_gen_tb_top.sv
// Bench: a behavioural reference model runs beside the design and every
// output is compared on every clock. Directed monitors also measure pulse
// widths, line lengths and sync edge relations. Short lines keep frames
// within the run budget.
module ivs_sync_gen_tb_top;

    localparam int SPL_A = 60;   // 525-line mode samples per line
    localparam int SPL_B = 64;   // 625-line mode samples per line
    localparam int HSW   = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fmt_625;
    logic       vbi_off;
    logic [1:0] cc_en;
    logic       hsync_n, vsync_n, field_odd, vblank, cc_gate;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ivs_sync_gen #(
        .SPL_525 (SPL_A),
        .SPL_625 (SPL_B),
        .HS_CLKS (HSW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_625   (fmt_625),
        .vbi_off   (vbi_off),
        .cc_en     (cc_en),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .field_odd (field_odd),
        .vblank    (vblank),
        .cc_gate   (cc_gate)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int mh = 0, mln = 1, mfmt = 0;
    bit e_hs = 1, e_vs = 1, e_fd = 0, e_vb = 0, e_cc = 0;
    bit e_valid = 0;

    function automatic bit ref_vs(int f, int ln, int hh);
        int half;
        half = (f != 0) ? SPL_B / 2 : SPL_A / 2;
        if (f == 0)
            return (ln <= 3) || (ln == 263 && hh >= half) || ln == 264 || ln == 265 ||
                   (ln == 266 && hh < half);
        else
            return (ln <= 2) || (ln == 3 && hh < half) || (ln == 313 && hh >= half) ||
                   ln == 314 || ln == 315;
    endfunction

    function automatic bit ref_odd(int f, int ln, int hh);
        if (f == 0) return (ln < 263) || (ln == 263 && hh < SPL_A / 2);
        else        return (ln < 313) || (ln == 313 && hh < SPL_B / 2);
    endfunction

    function automatic bit ref_blank(int f, int ln);
        if (f == 0) return (ln <= 21) || (ln >= 262 && ln <= 284) || ln == 525;
        else        return (ln <= 22) || (ln >= 311 && ln <= 335) || ln >= 624;
    endfunction

    // model step on each rising edge
    always @(posedge clk) begin
        int spl, nl;
        bit odd;
        if (!rst_n) begin
            mh = 0; mln = 1; mfmt = fmt_625;
            e_hs = 1; e_vs = 1; e_fd = 0; e_vb = 0; e_cc = 0;
        end else begin
            odd  = ref_odd(mfmt, mln, mh);
            e_hs = !(mh < HSW);
            e_vs = !ref_vs(mfmt, mln, mh);
            e_fd = odd;
            e_vb = ref_blank(mfmt, mln) && !vbi_off;
            e_cc = odd ? cc_en[1] : cc_en[0];
            spl  = (mfmt != 0) ? SPL_B : SPL_A;
            nl   = (mfmt != 0) ? 625 : 525;
            mh++;
            if (mh == spl) begin
                mh = 0;
                if (mln == nl) begin
                    mln = 1;
                    mfmt = fmt_625;
                end else begin
                    mln++;
                end
            end
        end
        e_valid = 1;
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (e_valid && !done) begin
            check(hsync_n == e_hs, "R2 hsync_n", hsync_n, e_hs);
            check(vsync_n == e_vs, (mfmt != 0) ? "R4 vsync_n" : "R3 vsync_n", vsync_n, e_vs);
            check(field_odd == e_fd, "R5 field_odd", field_odd, e_fd);
            check(vblank == e_vb, vbi_off ? "R7 vblank" : "R6 vblank", vblank, e_vb);
            check(cc_gate == e_cc, "R8 cc_gate", cc_gate, e_cc);
        end
    end

    // ---------------- directed edge monitors ----------------
    bit p_hs = 1, p_vs = 1, have_fall = 0;
    int hs_low = 0, vs_low = 0, since_fall = 0, prev_spl = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_hs = 1; p_vs = 1; have_fall = 0;
            hs_low = 0; vs_low = 0; since_fall = 0;
        end else if (!done) begin
            since_fall++;
            if (!vsync_n && p_vs) begin
                if (field_odd)
                    check(!hsync_n && p_hs, "R5 odd start edges coincide", hsync_n, 0);
                else
                    check(hsync_n, "R5 even start with hsync high", hsync_n, 1);
            end
            if (!hsync_n && p_hs) begin
                if (have_fall)
                    check(since_fall == prev_spl, "R2 line length", since_fall, prev_spl);
                have_fall = 1;
                since_fall = 0;
                prev_spl = (mfmt != 0) ? SPL_B : SPL_A;
            end
            if (hsync_n && !p_hs)
                check(hs_low == HSW, "R2 hsync width", hs_low, HSW);
            if (vsync_n && !p_vs) begin
                if (mfmt != 0) check(vs_low == 5 * SPL_B / 2, "R4 vsync 2.5 lines", vs_low, 5 * SPL_B / 2);
                else           check(vs_low == 3 * SPL_A, "R3 vsync 3 lines", vs_low, 3 * SPL_A);
            end
            hs_low = hsync_n ? 0 : hs_low + 1;
            vs_low = vsync_n ? 0 : vs_low + 1;
            p_hs = hsync_n;
            p_vs = vsync_n;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // measure clocks from one hsync fall to the next, starting at the next fall
    task automatic measure_line(output int len);
        bit prev;
        len = 0;
        prev = hsync_n;
        while (!(!hsync_n && prev)) begin
            prev = hsync_n;
            @(negedge clk);
        end
        prev = hsync_n;
        @(negedge clk);
        len = 1;
        while (!(!hsync_n && prev)) begin
            prev = hsync_n;
            @(negedge clk);
            len++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int len;
        rst_n = 0; fmt_625 = 0; vbi_off = 0; cc_en = 2'b10;
        wait_cycles(4);
        // R1: reset values
        check(hsync_n == 1, "R1 reset hsync_n", hsync_n, 1);
        check(vsync_n == 1, "R1 reset vsync_n", vsync_n, 1);
        check(field_odd == 0, "R1 reset field_odd", field_odd, 0);
        check(vblank == 0 && cc_gate == 0, "R1 reset vblank/cc_gate", {vblank, cc_gate}, 0);
        rst_n = 1;
        wait_cycles(1);
        // R1: first output is line 1 sample 0
        check(!hsync_n && !vsync_n && field_odd, "R1 first output odd start",
              {hsync_n, vsync_n, field_odd}, 1);
        // 525-line frame with control changes
        wait_cycles(5000);  cc_en = 2'b01;
        wait_cycles(10000); vbi_off = 1;
        wait_cycles(900);   vbi_off = 0;
        wait_cycles(4100);  cc_en = 2'b11;
        wait_cycles(5000);  cc_en = 2'b00;
        wait_cycles(3000);
        // R9: a format change in mid-frame keeps the current line length
        fmt_625 = 1;
        measure_line(len);
        check(len == SPL_A, "R9 old format holds mid-frame", len, SPL_A);
        cc_en = 2'b10;
        @(negedge clk);
        while (!(field_odd && !vsync_n)) @(negedge clk);
        measure_line(len);
        check(len == SPL_B, "R9 new format after frame wrap", len, SPL_B);
        // two 625-line frames
        wait_cycles(18000); vbi_off = 1;
        wait_cycles(2000);  vbi_off = 0; cc_en = 2'b01;
        wait_cycles(20000); cc_en = 2'b11;
        wait_cycles(40000);
        // reset in mid-frame back to 525 lines
        rst_n = 0; fmt_625 = 0;
        wait_cycles(3);
        check(hsync_n && vsync_n && !field_odd && !vblank && !cc_gate,
              "R1 reset mid-run", {hsync_n, vsync_n, field_odd, vblank, cc_gate}, 5'b11000);
        rst_n = 1;
        wait_cycles(1);
        check(!hsync_n && !vsync_n && field_odd, "R1 restart odd start",
              {hsync_n, vsync_n, field_odd}, 1);
        wait_cycles(2000);
        finish_run();
    end

endmodule